// File: doc/BRIEF.md
# Serial Management Bus Master (Clause 22 and Byte-Register SMI)

This block is the master side of a two-wire serial management bus, the kind used to configure Ethernet PHYs and small switches. From the system clock it makes the management clock (MDC). It shifts a complete 64-bit frame onto the bidirectional data line through a separate output and output-enable pair. For reads it samples the returned data from the line input. A single `start` strobe launches a frame, and the master stays busy until the frame has been fully clocked out.

Two frame flavours are supported, chosen per transfer by `smi_mode`.

- **Standard Clause 22 frames** carry the 5-bit PHY address and 5-bit register address as given. The opcode tells a read from a write.
- **The SMI variant** always sends opcode 00. It puts the direction into the top bit of the PHY field and spreads an 8-bit register number over the low three PHY bits and the five REG bits. Only the low byte of the data word is meaningful in this mode.

Top module: `mgmt_bus_master`

## Requirements
- R1: Each frame begins with 32 one bits followed by the start pair 0, 1. Bits are transmitted most-significant first in this order: start (2), opcode (2), PHY field (5), REG field (5), turnaround (2), data (16).
- R2: With `smi_mode`=0, the opcode is 10 for a read and 01 for a write. The PHY field is `phy_addr`, and the REG field is `reg_addr[4:0]`; `reg_addr[7:5]` has no effect on the frame.
- R3: With `smi_mode`=1, the opcode is 00 for both directions. The PHY field is {`rd_nwr`, 0, `reg_addr[7:5]`}, the REG field is `reg_addr[4:0]`, and `phy_addr` has no effect on the frame.
- R4: On a write, the turnaround is driven as 1 then 0. The data follows as 16 bits, MSB first: `wr_data` in standard mode, {8'h00, `wr_data[7:0]`} in SMI mode.
- R5: `mdio_oe` is 1 for every bit the master drives. On a read it is 0 from the first turnaround bit through the last data bit. It is 0 whenever the master is idle.
- R6: Read data is sampled from `mdio_i` on each rising MDC edge of the 16 data bits, MSB first. At completion, `rd_data` receives the 16 captured bits in standard mode, or {8'h00, captured low byte} in SMI mode. A write leaves `rd_data` unchanged.
- R7: MDC is low while idle and has a period of 2·`HALF_DIV` system clocks. `mdio_o` and `mdio_oe` change only while MDC is low, so they are stable at every rising MDC edge.
- R8: `busy` rises in the cycle after an accepted start and stays high for exactly 128·`HALF_DIV` cycles, covering exactly 64 MDC pulses. `done` pulses for one cycle as `busy` falls.
- R9: A `start` arriving while `busy` is high is ignored. The frame in progress completes unchanged, and no extra MDC pulses follow.
- R10: During and after reset, `mdc`, `mdio_oe`, `busy` and `done` are 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a frame (accepted only when idle) |
| smi_mode | input | 1 | 0 = standard Clause 22 frame, 1 = SMI byte-register frame |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address (standard mode only) |
| reg_addr | input | 8 | Register address; all 8 bits used in SMI mode, low 5 in standard mode |
| wr_data | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The main function is driven with standard and SMI frames in both directions.

- **Register addresses with the top three bits set** show whether standard mode ignores them and whether SMI mode routes them into the PHY field.
- **SMI frames with an unrelated `phy_addr`** show whether that input is dropped in SMI mode.
- **Read responses with a non-zero upper byte** show whether the SMI mode masks it while the standard mode passes it through.
- **A write between two reads** shows whether `rd_data` is held.
- **A start pulse with different inputs in mid-frame** shows whether a frame can be disturbed once launched.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int FRAME_BITS = 64;   // preamble + start + op + phy + reg + ta + data
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;   // transmit index of first turnaround bit
  localparam int DATA_POS   = 48;   // transmit index of first data bit
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef logic [FRAME_BITS-1:0] frame_t;

  // Line image of a frame, bit FRAME_BITS-1 goes out first.
  function automatic frame_t build_frame(input logic smi, input logic rd,
                                         input logic [4:0] phy, input logic [7:0] ra,
                                         input logic [15:0] wd);
    logic [1:0]  op;
    logic [4:0]  pf;
    logic [4:0]  rf;
    logic [1:0]  ta;
    logic [15:0] dat;
    rf = ra[4:0];
    if (smi) begin
      op  = 2'b00;
      pf  = {rd, 1'b0, ra[7:5]};
      dat = {8'h00, wd[7:0]};
    end else begin
      op  = rd ? 2'b10 : 2'b01;
      pf  = phy;
      dat = wd;
    end
    ta = rd ? 2'b00 : 2'b10;
    if (rd) dat = '0;
    return {{PRE_BITS{1'b1}}, 2'b01, op, pf, rf, ta, dat};
  endfunction

  // Output-enable image: released from turnaround onwards on a read.
  function automatic frame_t build_oe(input logic rd);
    if (rd) return {{TA_POS{1'b1}}, {(FRAME_BITS-TA_POS){1'b0}}};
    return '1;
  endfunction

  // Value presented on rd_data for a finished read.
  function automatic logic [15:0] shape_rd(input logic smi, input logic [15:0] cap);
    return smi ? {8'h00, cap[7:0]} : cap;
  endfunction

endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_cnt;
  logic          tick;

  assign tick     = run && (div_cnt == LAST);
  assign rise_evt = tick && !mdc;
  assign fall_evt = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      div_cnt <= '0;
      mdc     <= 1'b0;
    end else if (tick) begin
      div_cnt <= '0;
      mdc     <= !mdc;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mgmt_frame_shift.sv
module mgmt_frame_shift
  import mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  frame_t               frame_in,
  input  frame_t               oe_in,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 last_bit,
  output logic [15:0]          cap_data
);
  frame_t           dat_sr;
  frame_t           oe_sr;
  logic [IDX_W-1:0] bit_idx;
  logic             in_data;

  assign mdio_o   = dat_sr[FRAME_BITS-1];
  assign mdio_oe  = oe_sr[FRAME_BITS-1];
  assign last_bit = (bit_idx == IDX_W'(FRAME_BITS-1));
  assign in_data  = (bit_idx >= IDX_W'(DATA_POS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_sr   <= '0;
      oe_sr    <= '0;
      bit_idx  <= '0;
      cap_data <= '0;
    end else if (load) begin
      dat_sr   <= frame_in;
      oe_sr    <= oe_in;
      bit_idx  <= '0;
      cap_data <= '0;
    end else begin
      if (rise_evt && in_data)
        cap_data <= {cap_data[14:0], mdio_i};
      if (fall_evt) begin
        dat_sr  <= {dat_sr[FRAME_BITS-2:0], 1'b0};
        oe_sr   <= {oe_sr[FRAME_BITS-2:0], 1'b0};
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        smi_mode,
  input  logic        rd_nwr,
  input  logic [4:0]  phy_addr,
  input  logic [7:0]  reg_addr,
  input  logic [15:0] wr_data,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        accept;
  logic        rise_evt;
  logic        fall_evt;
  logic        fin_evt;
  logic        last_bit;
  logic        rd_q;
  logic        smi_q;
  logic        sr_o;
  logic        sr_oe;
  logic [15:0] cap_data;
  frame_t      frame_img;
  frame_t      oe_img;

  assign accept    = start && !busy;
  assign fin_evt   = fall_evt && last_bit;
  assign frame_img = build_frame(smi_mode, rd_nwr, phy_addr, reg_addr, wr_data);
  assign oe_img    = build_oe(rd_nwr);
  assign mdio_o    = busy && sr_o;
  assign mdio_oe   = busy && sr_oe;

  mgmt_mdc_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .mdc      (mdc),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  mgmt_frame_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (frame_img),
    .oe_in    (oe_img),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .mdio_i   (mdio_i),
    .mdio_o   (sr_o),
    .mdio_oe  (sr_oe),
    .last_bit (last_bit),
    .cap_data (cap_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_q    <= 1'b0;
      smi_q   <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= fin_evt;
      if (accept) begin
        busy  <= 1'b1;
        rd_q  <= rd_nwr;
        smi_q <= smi_mode;
      end else if (fin_evt) begin
        busy <= 1'b0;
        if (rd_q) rd_data <= shape_rd(smi_q, cap_data);
      end
    end
  end
endmodule

// File: rtl/mgmt_bus_checker.sv
module mgmt_bus_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic fin_evt
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc) else $error("mdc high while idle"); // R7

  AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)))
    else $error("line changed with mdc high"); // R7

  AST_OE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe) else $error("oe while idle"); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))) else $error("done not at busy fall"); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fin_evt) |=> busy) else $error("frame cut by start"); // R9
endmodule

bind mgmt_bus_master mgmt_bus_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .fin_evt (fin_evt)
);

// File: tb/mgmt_bus_master_test.sv
module mgmt_bus_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int NVEC       = 6;

  typedef struct packed {
    logic        smi;
    logic        rd;
    logic [4:0]  phy;
    logic [7:0]  ra;
    logic [15:0] wd;
    logic [15:0] resp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 5'h01, 8'hE4, 16'hA5C3, 16'h0000},  // std write, ra[7:5] set
    '{1'b0, 1'b1, 5'h1F, 8'h02, 16'h0000, 16'h1234},  // std read
    '{1'b1, 1'b0, 5'h0A, 8'hB7, 16'h12AB, 16'h0000},  // smi write
    '{1'b1, 1'b1, 5'h15, 8'h5A, 16'h0000, 16'hFF3C},  // smi read, upper byte dirty
    '{1'b0, 1'b1, 5'h00, 8'hFF, 16'h0000, 16'h8001},  // std read, ra[7:5] set
    '{1'b1, 1'b1, 5'h1F, 8'hFF, 16'hFFFF, 16'h00FF}   // smi read, top address
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic smi_mode = 1'b0;
  logic rd_nwr = 1'b0;
  logic [4:0] phy_addr = '0;
  logic [7:0] reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic mdio_i = 1'b1;
  logic busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rises = 0;
  logic [15:0] last_rd = 16'h0000;

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) cyc++;
  always @(posedge mdc) rises++;

  mgmt_bus_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .smi_mode(smi_mode), .rd_nwr(rd_nwr),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] want_line(input vec_t v);
    logic [1:0]  op  = v.smi ? 2'b00 : (v.rd ? 2'b10 : 2'b01);
    logic [4:0]  pf  = v.smi ? {v.rd, 1'b0, v.ra[7:5]} : v.phy;
    logic [15:0] dat = v.rd ? 16'h0000 : (v.smi ? {8'h00, v.wd[7:0]} : v.wd);
    return {32'hFFFF_FFFF, 2'b01, op, pf, v.ra[4:0], 2'b10, dat};
  endfunction

  function automatic logic [63:0] want_oe(input vec_t v);
    return v.rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  function automatic logic [63:0] target_line(input vec_t v);
    return v.rd ? {46'h3FFF_FFFF_FFFF, 1'b1, 1'b0, v.resp} : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic run_frame(input vec_t v, input bit intrude);
    logic [63:0] got_o, got_oe, tgt;
    int t0, t1, nbusy, r0;
    logic [63:0] exp_o, exp_oe;
    tgt    = target_line(v);
    exp_o  = want_line(v);
    exp_oe = want_oe(v);
    got_o  = '0;
    got_oe = '0;
    t0 = 0; t1 = 0; nbusy = 0;
    @(negedge clk);
    mdio_i = tgt[63];
    smi_mode = v.smi; rd_nwr = v.rd; phy_addr = v.phy; reg_addr = v.ra; wr_data = v.wd;
    r0 = rises;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      begin
        for (int k = 0; k < 64; k++) begin
          @(posedge mdc);
          #1;
          got_o[63-k]  = mdio_o;
          got_oe[63-k] = mdio_oe;
          if (k == 0) t0 = cyc;
          if (k == 1) t1 = cyc;
          mdio_i = (k < 63) ? tgt[62-k] : 1'b1;
        end
      end
      begin
        while (busy) begin
          nbusy++;
          if (intrude && nbusy == 100) begin
            start = 1'b1; smi_mode = !v.smi; rd_nwr = !v.rd;
            phy_addr = ~v.phy; reg_addr = ~v.ra; wr_data = ~v.wd;
          end else begin
            start = 1'b0;
          end
          @(negedge clk);
        end
      end
    join
    // R1 R2 R3 R4: driven bits of the frame
    chk((got_o & exp_oe) == (exp_o & exp_oe), "R1-frame R2 R3 R4 line", got_o, exp_o);
    chk(got_oe == exp_oe, "R5 oe pattern", got_oe, exp_oe);
    chk(nbusy == 128*HALF, "R8 busy length", 64'(nbusy), 64'(128*HALF));
    chk(t1 - t0 == 2*HALF, "R7 mdc period", 64'(t1 - t0), 64'(2*HALF));
    chk(done === 1'b1, "R8 done at busy fall", 64'(done), 64'd1);
    if (v.rd) last_rd = v.smi ? {8'h00, v.resp[7:0]} : v.resp;
    chk(rd_data === last_rd, "R6 rd_data", 64'(rd_data), 64'(last_rd));
    @(negedge clk);
    chk(done === 1'b0 && mdc === 1'b0, "R8 done single / R7 idle mdc", {62'h0, done, mdc}, 64'h0);
    repeat (4*HALF) @(negedge clk);
    chk(rises - r0 == 64, "R9 pulse count", 64'(rises - r0), 64'd64);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    chk({mdc, mdio_oe, busy, done} === 4'b0, "R10 reset outputs", 64'({mdc, mdio_oe, busy, done}), 64'h0);
    chk(rd_data === 16'h0, "R10 reset rd_data", 64'(rd_data), 64'h0);
    // start held during reset must not launch anything
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({mdc, busy} === 2'b0, "R10 idle after reset", 64'({mdc, busy}), 64'h0);

    for (int i = 0; i < NVEC; i++) run_frame(VECS[i], 1'b0);

    // R9: start in mid-frame with different inputs leaves frame intact
    run_frame(VECS[3], 1'b1);
    run_frame(VECS[0], 1'b1);

    // R6: a write keeps the last read value
    run_frame(VECS[2], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule